// File: doc/BRIEF.md
# Multi-Level I/O Translation Cache

This block is a small, fully associative cache of completed address translations for an I/O memory management unit. Each slot holds a tag (address-space ID, virtual-machine ID, aligned input address, granule code, table level) together with an output base address, the address mask that belongs to the slot's level, and a two-bit permission field. The page-table walker that fills it and the memory path around it are outside this block.

A single command port carries lookups, inserts and four kinds of invalidation. A lookup does not know in advance the level at which a translation was cached. It therefore probes one level per cycle. It starts at the shallowest level implied by the granule and the table size, steps towards level 3, and stops at the first hit. While a lookup runs, `busy` is high and any command offered is dropped. Invalidations and inserts finish in the cycle they are accepted. Two free-running counters record lookup hits and misses.

Top module: `iotlb_cache`

## Requirements
- R1: After reset no slot is valid, `busy` and `rspValid` are low, and both counters read zero.
- R2: A lookup hits a slot only if the ASID, VMID, granule code, level and level-aligned address all match. A mismatch in any one of these fields gives a miss.
- R3: A lookup (cmdOp 0) first computes inputsize = 64 − cmdTsz and stride = granule shift − 3, where the granule shift is 12, 14 or 16 for granule codes 1, 2 and 3. It then sets q = (inputsize − 4) / stride. The first probed level is 0 if q ≥ 4, level 3 if q = 0, and 4 − q otherwise. One level is probed per cycle up to level 3. `rspValid` pulses one cycle after the clock edge of the final probe, so it arrives N edges after acceptance for N probed levels, and `busy` stays high in between.
- R4: At level L the address is aligned to the block size 2^(shift + (3−L)·stride) before comparison. A hit returns `rspAddr` = (base with the mask bits cleared) OR (request address AND mask), together with the mask, the permission and the level. A miss returns zero in all four fields.
- R5: An insert (cmdOp 1) writes a slot with the tag aligned to its level. If a slot with the same tag already exists, that slot is overwritten. Otherwise the insert takes a free slot.
- R6: An insert that arrives when every slot is valid first clears all slots and then writes the new entry, so afterwards exactly that entry is cached.
- R7: Invalidate-all (cmdOp 2) clears every slot.
- R8: Invalidate-by-ASID (cmdOp 3) clears every slot whose ASID equals cmdAsid and leaves all other slots in place.
- R9: Invalidate-by-VMID (cmdOp 4) clears every slot whose VMID equals cmdVmid and leaves all other slots in place.
- R10: A ranged invalidate (cmdOp 5) computes the range mask (cmdPages << shift) − 1, where granule code 0 stands for the 4 KB shift of 12. A slot is cleared when both of these hold: (a) its ASID and VMID pass the filters, where cmdAsidAny and cmdVmidAny each make their filter pass for any value; (b) the request address, with the slot's mask bits cleared, equals the slot's base, or the slot's base, with the range mask bits cleared, equals the request address.
- R11: For a ranged invalidate with nonzero cmdLevel, cmdPages = 1 and both IDs specified, a slot whose full tag equals the request is first looked for. If one is found, only that slot is cleared. The range scan of R10 runs only when no such slot is found.
- R12: Each completed lookup increments exactly one counter: `hitCount` on a hit, `missCount` on a miss.
- R13: A command offered while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered |
| cmdOp | input | 3 | Opcode: 0 lookup, 1 insert, 2 inv-all, 3 inv-ASID, 4 inv-VMID, 5 ranged inv; 6 and 7 do nothing |
| cmdAsid | input | 16 | Address-space ID |
| cmdVmid | input | 16 | Virtual-machine ID |
| cmdAddr | input | 48 | Input address or range base |
| cmdGran | input | 2 | Granule code |
| cmdTsz | input | 6 | Table size field used for the lookup start level |
| cmdLevel | input | 2 | Insert level, or level hint for a ranged invalidate |
| cmdOutBase | input | 48 | Output base address for an insert |
| cmdPerm | input | 2 | Permission bits for an insert |
| cmdPages | input | 8 | Page count for a ranged invalidate |
| cmdAsidAny | input | 1 | ASID filter passes for any value |
| cmdVmidAny | input | 1 | VMID filter passes for any value |
| busy | output | 1 | Lookup in progress; commands are dropped |
| rspValid | output | 1 | One-cycle lookup result pulse |
| rspHit | output | 1 | Lookup hit |
| rspAddr | output | 48 | Translated address |
| rspMask | output | 48 | Mask of the hit slot |
| rspPerm | output | 2 | Permission of the hit slot |
| rspLevel | output | 2 | Level at which the hit occurred |
| hitCount | output | 16 | Number of lookup hits |
| missCount | output | 16 | Number of lookup misses |

## Verification
The assertions check on every cycle several properties that hold regardless of the cache contents. The probe level advances by one on each non-final probe, a result never coincides with `busy`, exactly one counter moves per result, and no probe matches more than one slot. They also check that invalidate-all and a flushing insert leave the expected number of valid slots. The effects that depend on contents can only be shown by the bench's scenarios, because they require knowing which entries were cached. These include which level answers first, the difference between exact-key and range removal, the containment test in both directions, and the dropping of commands during a lookup.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int ADDR_W = 48;
  localparam int ASID_W = 16;
  localparam int VMID_W = 16;
  localparam int PAGE_W = 8;
  localparam int CNT_W  = 16;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    OP_LOOKUP    = 3'd0,
    OP_INSERT    = 3'd1,
    OP_INV_ALL   = 3'd2,
    OP_INV_ASID  = 3'd3,
    OP_INV_VMID  = 3'd4,
    OP_INV_RANGE = 3'd5
  } op_e;

  typedef struct packed {
    logic              valid;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    addr_t             iova;
    logic [1:0]        gran;
    logic [1:0]        lvl;
    addr_t             outBase;
    addr_t             mask;
    logic [1:0]        perm;
  } tlbEntry_t;

  typedef struct packed {
    logic       latchReq;
    logic       doInsert;
    logic       doInvAll;
    logic       doInvAsid;
    logic       doInvVmid;
    logic       doInvRange;
    logic       captureRsp;
    logic [1:0] probeLevel;
  } ctlStrobe_t;

  // log2 of the granule; code 0 falls back to 4 KB
  function automatic logic [5:0] granShift(input logic [1:0] gran);
    return (gran == 2'd0) ? 6'd12 : 6'(6'd10 + {3'd0, gran, 1'b0});
  endfunction

  function automatic logic [6:0] levelShift(input logic [1:0] lvl, input logic [1:0] gran);
    logic [6:0] gs, stride, span;
    gs     = {1'b0, granShift(gran)};
    stride = gs - 7'd3;
    span   = 7'({5'd0, 2'(2'd3 - lvl)} * stride);
    return gs + span;
  endfunction

  function automatic addr_t maskOfShift(input logic [6:0] sh);
    if (sh >= 7'(ADDR_W)) return '1;
    return (addr_t'(1) << sh) - addr_t'(1);
  endfunction

  function automatic addr_t levelMask(input logic [1:0] lvl, input logic [1:0] gran);
    return maskOfShift(levelShift(lvl, gran));
  endfunction

  function automatic addr_t rangeMask(input logic [PAGE_W-1:0] pages, input logic [1:0] gran);
    return (addr_t'(pages) << granShift(gran)) - addr_t'(1);
  endfunction

  function automatic logic [1:0] startLevel(input logic [1:0] gran, input logic [5:0] tsz);
    logic [6:0] inSize, stride, q;
    inSize = 7'd64 - {1'b0, tsz};
    stride = {1'b0, granShift(gran)} - 7'd3;
    if (inSize < 7'd4) return 2'd3;
    q = (inSize - 7'd4) / stride;
    if (q >= 7'd4) return 2'd0;
    if (q == 7'd0) return 2'd3;
    return 2'(3'd4 - q[2:0]);
  endfunction
endpackage

// File: rtl/iotlb_ctrl.sv
module iotlb_ctrl
  import iotlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [1:0]       cmdGran,
  input  logic [5:0]       cmdTsz,
  input  logic             probeHit,
  output ctlStrobe_t       stb,
  output logic             busy,
  output logic             rspValid,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);
  typedef enum logic {ST_IDLE, ST_PROBE} state_e;

  state_e     state;
  logic [1:0] level;
  logic       accept;
  logic       lastProbe;

  assign busy      = (state == ST_PROBE);
  assign accept    = cmdValid && !busy;
  assign lastProbe = busy && (probeHit || level == 2'd3);

  always_comb begin
    stb            = '0;
    stb.latchReq   = accept && (cmdOp == OP_LOOKUP);
    stb.doInsert   = accept && (cmdOp == OP_INSERT);
    stb.doInvAll   = accept && (cmdOp == OP_INV_ALL);
    stb.doInvAsid  = accept && (cmdOp == OP_INV_ASID);
    stb.doInvVmid  = accept && (cmdOp == OP_INV_VMID);
    stb.doInvRange = accept && (cmdOp == OP_INV_RANGE);
    stb.captureRsp = lastProbe;
    stb.probeLevel = level;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      level     <= 2'd0;
      rspValid  <= 1'b0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      rspValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (stb.latchReq) begin
            state <= ST_PROBE;
            level <= startLevel(cmdGran, cmdTsz);
          end
        end
        ST_PROBE: begin
          if (lastProbe) begin
            state    <= ST_IDLE;
            rspValid <= 1'b1;
            if (probeHit) hitCount <= hitCount + 1'b1;
            else          missCount <= missCount + 1'b1;
          end else begin
            level <= level + 2'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !busy); // R3

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !probeHit && level != 2'd3) |=> (busy && level == $past(level) + 2'd1)); // R3

  AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((hitCount != $past(hitCount)) != (missCount != $past(missCount)))); // R12
endmodule

// File: rtl/iotlb_store.sv
module iotlb_store
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [ASID_W-1:0] cmdAsid,
  input  logic [VMID_W-1:0] cmdVmid,
  input  addr_t             cmdAddr,
  input  logic [1:0]        cmdGran,
  input  logic [1:0]        cmdLevel,
  input  addr_t             cmdOutBase,
  input  logic [1:0]        cmdPerm,
  input  logic [PAGE_W-1:0] cmdPages,
  input  logic              cmdAsidAny,
  input  logic              cmdVmidAny,
  output logic              probeHit,
  output logic              rspHit,
  output addr_t             rspAddr,
  output addr_t             rspMask,
  output logic [1:0]        rspPerm,
  output logic [1:0]        rspLevel
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlbEntry_t ent [ENTRIES];

  logic [ASID_W-1:0] reqAsid;
  logic [VMID_W-1:0] reqVmid;
  addr_t             reqAddr;
  logic [1:0]        reqGran;

  logic [ENTRIES-1:0] validVec, probeVec, insVec, exactVec, rangeVec;
  logic [ENTRIES-1:0] asidVec, vmidVec, killVec;
  logic [IDX_W-1:0]   probeIdx, freeIdx, insIdx, wrIdx;
  logic               full, exactOk;
  addr_t              probeMask, probeTag, insMask, insTag, rngMask;
  tlbEntry_t          newEntry;

  assign probeMask = levelMask(stb.probeLevel, reqGran);
  assign probeTag  = reqAddr & ~probeMask;
  assign insMask   = levelMask(cmdLevel, cmdGran);
  assign insTag    = cmdAddr & ~insMask;
  assign rngMask   = rangeMask(cmdPages, cmdGran);
  assign exactOk   = (cmdLevel != 2'd0) && (cmdPages == PAGE_W'(1)) && !cmdAsidAny && !cmdVmidAny;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic idsEq;
    assign idsEq       = (ent[i].asid == cmdAsid) && (ent[i].vmid == cmdVmid);
    assign validVec[i] = ent[i].valid;
    assign probeVec[i] = ent[i].valid && (ent[i].asid == reqAsid) && (ent[i].vmid == reqVmid)
                      && (ent[i].iova == probeTag) && (ent[i].gran == reqGran)
                      && (ent[i].lvl == stb.probeLevel);
    assign insVec[i]   = ent[i].valid && idsEq && (ent[i].iova == insTag)
                      && (ent[i].gran == cmdGran) && (ent[i].lvl == cmdLevel);
    assign exactVec[i] = ent[i].valid && idsEq && (ent[i].iova == cmdAddr)
                      && (ent[i].gran == cmdGran) && (ent[i].lvl == cmdLevel);
    assign asidVec[i]  = ent[i].valid && (ent[i].asid == cmdAsid);
    assign vmidVec[i]  = ent[i].valid && (ent[i].vmid == cmdVmid);
    assign rangeVec[i] = ent[i].valid
                      && (cmdAsidAny || ent[i].asid == cmdAsid)
                      && (cmdVmidAny || ent[i].vmid == cmdVmid)
                      && (((cmdAddr & ~ent[i].mask) == ent[i].iova)
                       || ((ent[i].iova & ~rngMask) == cmdAddr));
  end

  assign full     = &validVec;
  assign probeHit = |probeVec;
  assign killVec  = (exactOk && |exactVec) ? exactVec : rangeVec;

  always_comb begin
    probeIdx = '0;
    freeIdx  = '0;
    insIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (probeVec[i]) probeIdx = IDX_W'(i);
      if (!validVec[i]) freeIdx = IDX_W'(i);
      if (insVec[i])   insIdx  = IDX_W'(i);
    end
    if (full)         wrIdx = '0;
    else if (|insVec) wrIdx = insIdx;
    else              wrIdx = freeIdx;
  end

  always_comb begin
    newEntry         = '0;
    newEntry.valid   = 1'b1;
    newEntry.asid    = cmdAsid;
    newEntry.vmid    = cmdVmid;
    newEntry.iova    = insTag;
    newEntry.gran    = cmdGran;
    newEntry.lvl     = cmdLevel;
    newEntry.outBase = cmdOutBase;
    newEntry.mask    = insMask;
    newEntry.perm    = cmdPerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (stb.doInvAll || (stb.doInsert && full))    ent[i].valid <= 1'b0;
        else if (stb.doInvAsid && asidVec[i])          ent[i].valid <= 1'b0;
        else if (stb.doInvVmid && vmidVec[i])          ent[i].valid <= 1'b0;
        else if (stb.doInvRange && killVec[i])         ent[i].valid <= 1'b0;
      end
      if (stb.doInsert) ent[wrIdx] <= newEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAsid  <= '0;
      reqVmid  <= '0;
      reqAddr  <= '0;
      reqGran  <= '0;
      rspHit   <= 1'b0;
      rspAddr  <= '0;
      rspMask  <= '0;
      rspPerm  <= '0;
      rspLevel <= '0;
    end else begin
      if (stb.latchReq) begin
        reqAsid <= cmdAsid;
        reqVmid <= cmdVmid;
        reqAddr <= cmdAddr;
        reqGran <= cmdGran;
      end
      if (stb.captureRsp) begin
        rspHit <= probeHit;
        if (probeHit) begin
          rspAddr  <= (ent[probeIdx].outBase & ~ent[probeIdx].mask) | (reqAddr & ent[probeIdx].mask);
          rspMask  <= ent[probeIdx].mask;
          rspPerm  <= ent[probeIdx].perm;
          rspLevel <= stb.probeLevel;
        end else begin
          rspAddr  <= '0;
          rspMask  <= '0;
          rspPerm  <= '0;
          rspLevel <= '0;
        end
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(probeVec)); // R5

  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rstN)
    stb.doInvAll |=> (validVec == '0)); // R7

  AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doInsert && full) |=> ($countones(validVec) == 1)); // R6
endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ASID_W-1:0] cmdAsid,
  input  logic [VMID_W-1:0] cmdVmid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [1:0]        cmdGran,
  input  logic [5:0]        cmdTsz,
  input  logic [1:0]        cmdLevel,
  input  logic [ADDR_W-1:0] cmdOutBase,
  input  logic [1:0]        cmdPerm,
  input  logic [PAGE_W-1:0] cmdPages,
  input  logic              cmdAsidAny,
  input  logic              cmdVmidAny,
  output logic              busy,
  output logic              rspValid,
  output logic              rspHit,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W-1:0] rspMask,
  output logic [1:0]        rspPerm,
  output logic [1:0]        rspLevel,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  ctlStrobe_t stb;
  logic       probeHit;

  iotlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdGran(cmdGran), .cmdTsz(cmdTsz), .probeHit(probeHit),
    .stb(stb), .busy(busy), .rspValid(rspValid),
    .hitCount(hitCount), .missCount(missCount)
  );

  iotlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdAsid(cmdAsid), .cmdVmid(cmdVmid), .cmdAddr(cmdAddr), .cmdGran(cmdGran),
    .cmdLevel(cmdLevel), .cmdOutBase(cmdOutBase), .cmdPerm(cmdPerm),
    .cmdPages(cmdPages), .cmdAsidAny(cmdAsidAny), .cmdVmidAny(cmdVmidAny),
    .probeHit(probeHit), .rspHit(rspHit), .rspAddr(rspAddr), .rspMask(rspMask),
    .rspPerm(rspPerm), .rspLevel(rspLevel)
  );
endmodule

// File: tb/iotlb_cache_bench.sv
module iotlb_cache_bench;
  import iotlb_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, cmdValid, cmdAsidAny, cmdVmidAny;
  logic [2:0]  cmdOp;
  logic [15:0] cmdAsid, cmdVmid;
  logic [47:0] cmdAddr, cmdOutBase;
  logic [1:0]  cmdGran, cmdLevel, cmdPerm;
  logic [5:0]  cmdTsz;
  logic [7:0]  cmdPages;
  logic        busy, rspValid, rspHit;
  logic [47:0] rspAddr, rspMask;
  logic [1:0]  rspPerm, rspLevel;
  logic [15:0] hitCount, missCount;

  iotlb_cache u_iotlb_cache (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAsid(cmdAsid), .cmdVmid(cmdVmid), .cmdAddr(cmdAddr), .cmdGran(cmdGran),
    .cmdTsz(cmdTsz), .cmdLevel(cmdLevel), .cmdOutBase(cmdOutBase), .cmdPerm(cmdPerm),
    .cmdPages(cmdPages), .cmdAsidAny(cmdAsidAny), .cmdVmidAny(cmdVmidAny),
    .busy(busy), .rspValid(rspValid), .rspHit(rspHit), .rspAddr(rspAddr),
    .rspMask(rspMask), .rspPerm(rspPerm), .rspLevel(rspLevel),
    .hitCount(hitCount), .missCount(missCount)
  );

  typedef struct {
    logic [15:0] asid, vmid;
    logic [47:0] iova, outBase;
    int          gran, lvl;
    logic [1:0]  perm;
  } mEnt_t;

  mEnt_t mdl[$];
  int nChecks = 0, nFails = 0, expHits = 0, expMisses = 0;
  bit done = 0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int gshOf(input int gran);
    return (gran == 0) ? 12 : 10 + 2 * gran;
  endfunction

  function automatic logic [47:0] lvlMask(input int lvl, input int gran);
    int gs = gshOf(gran);
    int sh = gs + (3 - lvl) * (gs - 3);
    if (sh >= 48) return '1;
    return (48'(1) << sh) - 48'(1);
  endfunction

  function automatic int firstLevel(input int gran, input int tsz);
    int inSize = 64 - tsz;
    int q;
    if (inSize < 4) return 3;
    q = (inSize - 4) / (gshOf(gran) - 3);
    if (q >= 4) return 0;
    if (q == 0) return 3;
    return 4 - q;
  endfunction

  task automatic idleFields();
    cmdValid = 0; cmdOp = 3'd7; cmdAsid = 0; cmdVmid = 0; cmdAddr = 0; cmdGran = 0;
    cmdTsz = 0; cmdLevel = 0; cmdOutBase = 0; cmdPerm = 0; cmdPages = 0;
    cmdAsidAny = 0; cmdVmidAny = 0;
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic fire();
    cmdValid = 1;
    @(posedge clk);
    @(negedge clk);
    idleFields();
  endtask

  task automatic doInsert(input int a, input int v, input logic [47:0] addr, input int gran,
                          input int lvl, input logic [47:0] ob, input logic [1:0] perm);
    mEnt_t e;
    int found = -1;
    if (mdl.size() >= 16) mdl.delete();
    e.asid = 16'(a); e.vmid = 16'(v); e.gran = gran; e.lvl = lvl;
    e.iova = addr & ~lvlMask(lvl, gran); e.outBase = ob; e.perm = perm;
    foreach (mdl[k])
      if (mdl[k].asid == e.asid && mdl[k].vmid == e.vmid && mdl[k].iova == e.iova &&
          mdl[k].gran == gran && mdl[k].lvl == lvl) found = k;
    if (found >= 0) mdl[found] = e; else mdl.push_back(e);
    cmdOp = OP_INSERT; cmdAsid = 16'(a); cmdVmid = 16'(v); cmdAddr = addr;
    cmdGran = 2'(gran); cmdLevel = 2'(lvl); cmdOutBase = ob; cmdPerm = perm;
    fire();
  endtask

  task automatic doInvAll();
    mdl.delete();
    cmdOp = OP_INV_ALL;
    fire();
  endtask

  task automatic doInvAsid(input int a);
    for (int k = mdl.size() - 1; k >= 0; k--) if (mdl[k].asid == 16'(a)) mdl.delete(k);
    cmdOp = OP_INV_ASID; cmdAsid = 16'(a);
    fire();
  endtask

  task automatic doInvVmid(input int v);
    for (int k = mdl.size() - 1; k >= 0; k--) if (mdl[k].vmid == 16'(v)) mdl.delete(k);
    cmdOp = OP_INV_VMID; cmdVmid = 16'(v);
    fire();
  endtask

  task automatic doInvRange(input int a, input bit aAny, input int v, input bit vAny,
                            input logic [47:0] addr, input int gran, input int pages, input int lvl);
    logic [47:0] rm = (48'(pages) << gshOf(gran)) - 48'(1);
    int exact = -1;
    if (lvl != 0 && pages == 1 && !aAny && !vAny)
      foreach (mdl[k])
        if (mdl[k].asid == 16'(a) && mdl[k].vmid == 16'(v) && mdl[k].iova == addr &&
            mdl[k].gran == gran && mdl[k].lvl == lvl) exact = k;
    if (exact >= 0) mdl.delete(exact);
    else
      for (int k = mdl.size() - 1; k >= 0; k--)
        if ((aAny || mdl[k].asid == 16'(a)) && (vAny || mdl[k].vmid == 16'(v)) &&
            (((addr & ~lvlMask(mdl[k].lvl, mdl[k].gran)) == mdl[k].iova) ||
             ((mdl[k].iova & ~rm) == addr))) mdl.delete(k);
    cmdOp = OP_INV_RANGE; cmdAsid = 16'(a); cmdVmid = 16'(v); cmdAsidAny = aAny;
    cmdVmidAny = vAny; cmdAddr = addr; cmdGran = 2'(gran); cmdPages = 8'(pages);
    cmdLevel = 2'(lvl);
    fire();
  endtask

  // reference lookup compared cycle by cycle; inject offers inv-all while busy
  task automatic doLookup(input int a, input int v, input logic [47:0] addr, input int gran,
                          input int tsz, input bit inject, input string req);
    int start = firstLevel(gran, tsz);
    int probes = 0, hitK = -1, hitL = 0;
    logic [47:0] m = '0;
    for (int l = start; l <= 3 && hitK < 0; l++) begin
      probes++;
      foreach (mdl[k])
        if (mdl[k].asid == 16'(a) && mdl[k].vmid == 16'(v) && mdl[k].gran == gran &&
            mdl[k].lvl == l && mdl[k].iova == (addr & ~lvlMask(l, gran))) begin
          hitK = k; hitL = l;
        end
    end
    cmdOp = OP_LOOKUP; cmdAsid = 16'(a); cmdVmid = 16'(v); cmdAddr = addr;
    cmdGran = 2'(gran); cmdTsz = 6'(tsz); cmdValid = 1;
    @(posedge clk);
    @(negedge clk);
    idleFields();
    if (inject) begin cmdOp = OP_INV_ALL; cmdValid = 1; end
    for (int c = 0; c < probes; c++) begin
      check("R3", "busy during probe", 64'(busy), 64'(1));
      check("R3", "early result", 64'(rspValid), 64'(0));
      @(negedge clk);
    end
    idleFields();
    check("R3", "result pulse", 64'(rspValid), 64'(1));
    check("R3", "busy after result", 64'(busy), 64'(0));
    check(req, "hit", 64'(rspHit), 64'(hitK >= 0));
    if (hitK >= 0) begin
      m = lvlMask(hitL, gran);
      expHits++;
      check("R4", "address", 64'(rspAddr), 64'((mdl[hitK].outBase & ~m) | (addr & m)));
      check("R4", "mask", 64'(rspMask), 64'(m));
      check("R4", "perm", 64'(rspPerm), 64'(mdl[hitK].perm));
      check("R4", "level", 64'(rspLevel), 64'(hitL));
    end else begin
      expMisses++;
      check("R4", "miss address", 64'(rspAddr), 64'(0));
    end
    check("R12", "hit counter", 64'(hitCount), 64'(expHits));
    check("R12", "miss counter", 64'(missCount), 64'(expMisses));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    idleFields();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy", 64'(busy), 64'(0));
    check("R1", "rspValid", 64'(rspValid), 64'(0));
    check("R1", "hitCount", 64'(hitCount), 64'(0));
    check("R1", "missCount", 64'(missCount), 64'(0));
    doLookup(1, 1, 48'h0000_1234_5abc, 1, 16, 0, "R1");

    // R3 R4 page and block hits at different start levels
    doInsert(1, 1, 48'h0000_1234_5000, 1, 3, 48'h0008_0000_0000, 2'd3);
    doLookup(1, 1, 48'h0000_1234_5abc, 1, 16, 0, "R3");
    doLookup(1, 1, 48'h0000_1234_5abc, 1, 25, 0, "R3");
    doLookup(1, 1, 48'h0000_1234_5abc, 1, 43, 0, "R3");
    doInsert(1, 1, 48'h0000_4020_0000, 1, 2, 48'h0001_0000_0000, 2'd1);
    doLookup(1, 1, 48'h0000_4031_2345, 1, 16, 0, "R4");
    doInsert(1, 1, 48'h0000_5000_0000, 3, 2, 48'h0002_0000_0000, 2'd2);
    doLookup(1, 1, 48'h0000_5000_1234, 3, 16, 0, "R4");

    // R2 single-field mismatches
    doLookup(2, 1, 48'h0000_1234_5abc, 1, 16, 0, "R2");
    doLookup(1, 2, 48'h0000_1234_5abc, 1, 16, 0, "R2");
    doLookup(1, 1, 48'h0000_1234_5abc, 3, 16, 0, "R2");

    // R5 same tag replaces
    doInsert(1, 1, 48'h0000_1234_5777, 1, 3, 48'h0009_0000_0000, 2'd2);
    doLookup(1, 1, 48'h0000_1234_5010, 1, 16, 0, "R5");

    // R8 and R9
    doInsert(2, 1, 48'h0000_0100_0000, 1, 3, 48'h0000_0aaa_0000, 2'd1);
    doInsert(3, 7, 48'h0000_0200_0000, 1, 3, 48'h0000_0bbb_0000, 2'd1);
    doInvAsid(2);
    doLookup(2, 1, 48'h0000_0100_0000, 1, 16, 0, "R8");
    doLookup(1, 1, 48'h0000_1234_5000, 1, 16, 0, "R8");
    doInvVmid(7);
    doLookup(3, 7, 48'h0000_0200_0000, 1, 16, 0, "R9");
    doLookup(1, 1, 48'h0000_4020_0000, 1, 16, 0, "R9");

    // R10 containment both ways, wildcard IDs, code 0 means 4 KB
    doInvRange(0, 1, 0, 1, 48'h0000_4030_0000, 0, 1, 0);
    doLookup(1, 1, 48'h0000_4031_2345, 1, 16, 0, "R10");
    doInsert(4, 4, 48'h0000_6000_3000, 1, 3, 48'h0000_0ccc_0000, 2'd3);
    doInsert(4, 4, 48'h0000_6000_9000, 1, 3, 48'h0000_0ddd_0000, 2'd3);
    doInvRange(4, 0, 0, 1, 48'h0000_6000_0000, 1, 8, 0);
    doLookup(4, 4, 48'h0000_6000_3000, 1, 16, 0, "R10");
    doLookup(4, 4, 48'h0000_6000_9000, 1, 16, 0, "R10");

    // R11 exact key removal spares a containing block
    doInsert(5, 5, 48'h0000_7000_0000, 1, 3, 48'h0000_0eee_0000, 2'd3);
    doInsert(5, 5, 48'h0000_7000_0000, 1, 2, 48'h0000_0fe0_0000, 2'd1);
    doInvRange(5, 0, 5, 0, 48'h0000_7000_0000, 1, 1, 3);
    doLookup(5, 5, 48'h0000_7000_0000, 1, 16, 0, "R11");
    doInvRange(5, 0, 5, 0, 48'h0000_7000_0000, 1, 1, 3);
    doLookup(5, 5, 48'h0000_7000_0000, 1, 16, 0, "R11");

    // R13 command dropped while busy
    doLookup(1, 1, 48'h0000_1234_5000, 1, 16, 1, "R13");
    doLookup(1, 1, 48'h0000_1234_5000, 1, 16, 0, "R13");

    // R7 and R6
    doInvAll();
    doLookup(1, 1, 48'h0000_1234_5000, 1, 16, 0, "R7");
    for (int i = 0; i < 16; i++)
      doInsert(6, 6, 48'h0000_1000_0000 + 48'(i) * 48'h1000, 1, 3, 48'h0000_3000_0000 + 48'(i) * 48'h1000, 2'd1);
    doLookup(6, 6, 48'h0000_1000_0000, 1, 16, 0, "R6");
    doLookup(6, 6, 48'h0000_1000_f000, 1, 16, 0, "R6");
    doInsert(6, 6, 48'h0000_2000_0000, 1, 3, 48'h0000_0123_0000, 2'd2);
    doLookup(6, 6, 48'h0000_1000_0000, 1, 16, 0, "R6");
    doLookup(6, 6, 48'h0000_2000_0abc, 1, 16, 0, "R6");

    done = 1;
    summary();
  end
endmodule